// File: doc/BRIEF.md
# Cascadable Four-Channel Down-Counting Timer Group

The block holds four down-counting timer channels behind a small 32-bit register bus. Each channel counts prescaled clock ticks from a programmable base value. When it reaches zero it pulls its active-low, level-type interrupt line and reloads, so it fires again and again until software halts it. Software starts and halts a channel through a stop flag held in the top bit of the channel's base-count register. Software acknowledges an interrupt by writing that channel's base-count or current-count register.

One shared group control register sets the common prescaler (divide by 8, 16, 32 or 64). It can also join neighbouring channels into a wide timer, in which the lower channel's borrow steps the upper channel. A second set of control bits picks what the lower channel reloads after a borrow. Interrupt routing, priority and channel allocation belong to the surrounding system.

Top module: `cascade_timer_group`

## Requirements
- R1: After reset every current count reads 0, every base count reads 0x8000_0000 (stop flag set), the vector, destination and group control registers read 0, and all four `irq_n` lines are high.
- R2: Channel n's registers sit at byte offset n*0x40: +0x00 current count, +0x10 base count, +0x20 vector, +0x30 destination. The group control register sits at 0x100. A read returns its data on `bus_rdata` one clock after the `bus_rd` cycle. A write of any value to a current count sets it to 0. The vector and destination registers store and return all 32 bits.
- R3: Group control bits 9:8 select the tick period in clocks: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R4: While bit 31 of a standalone channel's base count is 1, its current count does not change.
- R5: A running standalone channel acts on each tick. At a count of 0 it loads base bits 30:0; otherwise it decrements. Its interrupts therefore come (base+1) ticks apart.
- R6: In the clock edge where a channel's count steps to 0, its `irq_n` goes low. The line stays low through any later expiries until software writes that channel's base count or current count.
- R7: Group control bit k (k = 0..2) joins channel k (lower) with channel k+1 (upper). If bits k-1 and k are both set, bit k-1 wins and bit k is ignored.
- R8: In a joined pair, the upper channel's stop flag gates both channels. The lower channel counts on each tick. When the lower channel is 0 at a tick, a nonzero upper channel decrements and the lower channel reloads. If both are 0, the upper channel loads its base bits 30:0 and the lower channel loads all 32 bits of its base.
- R9: Group control bit 24+k selects the lower channel's reload after a borrow in pair k. When the bit is set, the lower channel loads 0xFFFF_FFFE, so the pair spans upper*0xFFFF_FFFF + lower ticks. When the bit is clear, the lower channel loads its own base. The period is then 1 + L + H*(L+1) ticks.
- R10: In a joined pair only the upper channel interrupts, on the edge where both counts become 0. The lower channel's `irq_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| irq_n | output | 4 | Per-channel interrupt, active low, level |

## Verification
Register reads complete one clock after the strobe, so every readback is sampled at the falling edge that follows the capturing rising edge. An interrupt falls on the rising edge where the count reaches zero, and the bench timestamps each fall at the next falling edge. Periods are then compared as differences between two falls. This keeps the result independent of the free-running prescaler phase. Count values read after a delay, whose exact tick phase cannot be known, are checked against bounds worked out from the slowest and fastest tick alignment.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
    localparam int DATA_W    = 32;
    localparam int STOP_BIT  = 31;
    localparam int CH_STRIDE = 64;
    localparam int CH_LSB    = 6;
    localparam int REG_LSB   = 4;
    localparam int DIV_LSB   = 8;
    localparam int ROLL_OFS  = 24;
    localparam int TICK_LOG2 = 3;
    localparam logic [DATA_W-1:0] BORROW_VAL = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_BASE  = 2'd1,
        REG_VEC   = 2'd2,
        REG_DEST  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ctg_prescaler.sv
module ctg_prescaler #(
    parameter int SEL_W     = 2,
    parameter int BASE_LOG2 = 3,
    localparam int CNT_W    = BASE_LOG2 + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        s_d      = s_q;
        s_d.cnt  = s_q.cnt + 1'b1;
        mask     = CNT_W'((1 << (BASE_LOG2 + int'(div_sel))) - 1);
        tick     = (s_q.cnt & mask) == mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: the shortest tick period is 8 clocks, so ticks never come back to back
    assert_tick_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ctg_chain_map.sv
module ctg_chain_map #(
    parameter int NCH = 4
) (
    input  logic [NCH-2:0] chain_req,
    output logic [NCH-2:0] pair_eff
);
    generate
        for (genvar k = 0; k < NCH - 1; k++) begin : g_pair
            if (k == 0) begin : g_first
                assign pair_eff[k] = chain_req[k];
            end else begin : g_rest
                assign pair_eff[k] = chain_req[k] && !pair_eff[k-1];
            end
        end
    endgenerate

    // R7: no channel may be the upper of one pair and the lower of the next
    always_comb begin
        assert_no_overlap_R7: assert ((pair_eff & (pair_eff >> 1)) == '0);
    end
endmodule

// File: rtl/ctg_core.sv
module ctg_core
    import ctg_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = $clog2(NCH * CH_STRIDE + 1),
    localparam int CTRL_OFS = NCH * CH_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NCH-2:0]    pair_eff,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl,
    output logic [NCH-1:0]    irq_n
);
    localparam logic [DATA_W-1:0] LINK_BITS = DATA_W'((64'd1 << (NCH - 1)) - 1);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(3) << DIV_LSB) | LINK_BITS | (LINK_BITS << ROLL_OFS);

    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] cnt;
        logic [NCH-1:0][DATA_W-1:0] base;
        logic [NCH-1:0][DATA_W-1:0] vec;
        logic [NCH-1:0][DATA_W-1:0] dest;
        logic [DATA_W-1:0]          ctrl;
        logic [NCH-1:0]             pend;
        logic [DATA_W-1:0]          rdata;
    } core_state_t;

    core_state_t s_d, s_q;

    logic [CH_W-1:0] ch_sel;
    reg_sel_e        reg_sel;
    logic            hit_ch, hit_ctrl;
    logic [NCH-1:0]  is_lower, is_upper, own_run, roll;
    logic [NCH-1:0]  ch_wr, ch_ack;

    assign ch_sel   = bus_addr[CH_LSB +: CH_W];
    assign reg_sel  = reg_sel_e'(bus_addr[REG_LSB +: 2]);
    assign hit_ch   = (bus_addr < ADDR_W'(CTRL_OFS)) && (bus_addr[REG_LSB-1:0] == '0);
    assign hit_ctrl = bus_addr == ADDR_W'(CTRL_OFS);
    assign is_lower = {1'b0, pair_eff};
    assign is_upper = {pair_eff, 1'b0};
    assign roll     = {1'b0, s_q.ctrl[ROLL_OFS +: NCH-1]};

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            own_run[i] = !s_q.base[i][STOP_BIT];
            ch_wr[i]   = bus_wr && hit_ch && (ch_sel == CH_W'(i));
            ch_ack[i]  = ch_wr[i] && (reg_sel == REG_COUNT || reg_sel == REG_BASE);
        end
    end

    always_comb begin
        int lo;
        s_d       = s_q;
        s_d.rdata = '0;
        lo        = 0;

        // counting: lower channels of a pair are stepped by their upper partner
        for (int i = 0; i < NCH; i++) begin
            lo = (i == 0) ? 0 : i - 1;
            if (tick && own_run[i] && !is_lower[i]) begin
                if (is_upper[i]) begin
                    if (s_q.cnt[lo] != '0) begin
                        s_d.cnt[lo] = s_q.cnt[lo] - 1'b1;
                    end else if (s_q.cnt[i] != '0) begin
                        s_d.cnt[i]  = s_q.cnt[i] - 1'b1;
                        s_d.cnt[lo] = roll[lo] ? BORROW_VAL : s_q.base[lo];
                    end else begin
                        s_d.cnt[i]  = {1'b0, s_q.base[i][STOP_BIT-1:0]};
                        s_d.cnt[lo] = s_q.base[lo];
                    end
                    if (s_d.cnt[i] == '0 && s_d.cnt[lo] == '0 &&
                        (s_q.cnt[i] != '0 || s_q.cnt[lo] != '0))
                        s_d.pend[i] = 1'b1;
                end else begin
                    if (s_q.cnt[i] == '0) begin
                        s_d.cnt[i] = {1'b0, s_q.base[i][STOP_BIT-1:0]};
                    end else begin
                        s_d.cnt[i] = s_q.cnt[i] - 1'b1;
                        if (s_q.cnt[i] == DATA_W'(1)) s_d.pend[i] = 1'b1;
                    end
                end
            end
        end

        // bus writes take precedence over counting in the same cycle
        if (bus_wr) begin
            if (hit_ctrl) begin
                s_d.ctrl = bus_wdata & CTRL_MASK;
            end else if (hit_ch) begin
                unique case (reg_sel)
                    REG_COUNT: begin
                        s_d.cnt[ch_sel]  = '0;
                        s_d.pend[ch_sel] = 1'b0;
                    end
                    REG_BASE: begin
                        s_d.base[ch_sel] = bus_wdata;
                        s_d.pend[ch_sel] = 1'b0;
                    end
                    REG_VEC:  s_d.vec[ch_sel]  = bus_wdata;
                    REG_DEST: s_d.dest[ch_sel] = bus_wdata;
                endcase
            end
        end

        if (bus_rd) begin
            if (hit_ctrl) begin
                s_d.rdata = s_q.ctrl;
            end else if (hit_ch) begin
                unique case (reg_sel)
                    REG_COUNT: s_d.rdata = s_q.cnt[ch_sel];
                    REG_BASE:  s_d.rdata = s_q.base[ch_sel];
                    REG_VEC:   s_d.rdata = s_q.vec[ch_sel];
                    REG_DEST:  s_d.rdata = s_q.dest[ch_sel];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < NCH; i++) s_q.base[i] <= DATA_W'(1) << STOP_BIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign ctrl      = s_q.ctrl;
    assign irq_n     = ~s_q.pend;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            // R4: a halted standalone channel keeps its count
            assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!is_lower[g] && !is_upper[g] && !own_run[g] && !ch_wr[g])
                |=> $stable(s_q.cnt[g]));
            // R5: a running standalone channel steps down by one per tick
            assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && own_run[g] && !is_lower[g] && !is_upper[g] &&
                 s_q.cnt[g] != '0 && !ch_wr[g])
                |=> s_q.cnt[g] == $past(s_q.cnt[g]) - 1'b1);
            // R6: an interrupt is held until acknowledged
            assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (!irq_n[g] && !ch_ack[g]) |=> !irq_n[g]);
            // R10: a lower channel of a pair never raises its own interrupt
            assert_lower_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (is_lower[g] && irq_n[g]) |=> irq_n[g]);
        end
    endgenerate
endmodule

// File: rtl/cascade_timer_group.sv
module cascade_timer_group
    import ctg_pkg::*;
#(
    parameter int NCH = 4,
    localparam int ADDR_W = $clog2(NCH * CH_STRIDE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq_n
);
    logic              tick;
    logic [NCH-2:0]    pair_eff;
    logic [DATA_W-1:0] ctrl;

    ctg_prescaler #(.SEL_W(2), .BASE_LOG2(TICK_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (ctrl[DIV_LSB +: 2]),
        .tick    (tick)
    );

    ctg_chain_map #(.NCH(NCH)) u_map (
        .chain_req (ctrl[NCH-2:0]),
        .pair_eff  (pair_eff)
    );

    ctg_core #(.NCH(NCH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pair_eff  (pair_eff),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .irq_n     (irq_n)
    );
endmodule

// File: tb/cascade_timer_group_bench.sv
module cascade_timer_group_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_n;

    int checks = 0;
    int fails  = 0;
    int unsigned cyc = 0;
    logic [3:0]  irq_prev = 4'hF;
    int unsigned fall_cnt [4] = '{0, 0, 0, 0};
    int unsigned fall_at  [4] = '{0, 0, 0, 0};

    localparam int NVEC = 5;
    localparam int TV_DIV    [NVEC] = '{0, 1, 2, 3, 0};
    localparam int TV_BASE   [NVEC] = '{3, 2, 1, 2, 10};
    localparam int TV_PERIOD [NVEC] = '{32, 48, 64, 192, 88};

    cascade_timer_group u_cascade_timer_group (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (irq_prev[c] && !irq_n[c]) begin
                fall_cnt[c] = fall_cnt[c] + 1;
                fall_at[c]  = cyc;
            end
        end
        irq_prev = irq_n;
    end

    function automatic logic [8:0] ra(input int ch, input int r);
        return 9'(ch * 64 + r * 16);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_fall(input int c, input int unsigned n0, input string tag);
        int k = 0;
        while (fall_cnt[c] == n0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (fall_cnt[c] == n0) check(1'b0, tag, 32'(fall_cnt[c]), 32'(n0 + 1));
    endtask

    task automatic measure(input int c, input logic [31:0] base_v, input int exp, input string tag);
        int unsigned t1, t2;
        wait_fall(c, fall_cnt[c], tag);
        t1 = fall_at[c];
        wr(ra(c, 1), base_v);
        wait_fall(c, fall_cnt[c], tag);
        t2 = fall_at[c];
        check((t2 - t1) == 32'(exp), tag, t2 - t1, 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b;
        int unsigned n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(irq_n == 4'hF, "R1 irq_n idle", 32'(irq_n), 32'hF);
        rd(ra(0, 0), v); check(v == 32'h0, "R1 count reset", v, 32'h0);
        rd(ra(3, 1), v); check(v == 32'h8000_0000, "R1 base reset", v, 32'h8000_0000);
        rd(9'h100, v);   check(v == 32'h0, "R1 ctrl reset", v, 32'h0);
        rd(ra(1, 2), v); check(v == 32'h0, "R1 vec reset", v, 32'h0);

        // R2: storage registers
        wr(ra(2, 2), 32'hA5A5_1234);
        wr(ra(3, 3), 32'h0F0F_8001);
        rd(ra(2, 2), v); check(v == 32'hA5A5_1234, "R2 vec storage", v, 32'hA5A5_1234);
        rd(ra(3, 3), v); check(v == 32'h0F0F_8001, "R2 dest storage", v, 32'h0F0F_8001);

        // R3 R5: periods from the vector table, channel 0 standalone
        for (int t = 0; t < NVEC; t++) begin
            wr(9'h100, 32'(TV_DIV[t]) << 8);
            wr(ra(0, 1), 32'(TV_BASE[t]));
            measure(0, 32'(TV_BASE[t]), TV_PERIOD[t], "R3 R5 period");
        end
        wr(ra(0, 1), 32'h8000_0000);
        wr(ra(0, 0), 32'h0);
        wr(9'h100, 32'h0);

        // R5: count loads base then decrements
        wr(ra(2, 1), 32'd50);
        repeat (40) @(negedge clk);
        rd(ra(2, 0), v);
        check(v >= 32'd44 && v <= 32'd50, "R5 count range", v, 32'd47);

        // R4: halted count holds
        wr(ra(2, 1), 32'h8000_0032);
        rd(ra(2, 0), a);
        repeat (80) @(negedge clk);
        rd(ra(2, 0), b);
        check(a == b && a != 0, "R4 halted hold", b, a);

        // R2: write to current count clears it
        wr(ra(2, 0), 32'h1234);
        rd(ra(2, 0), v); check(v == 32'h0, "R2 count clear", v, 32'h0);

        // R6: interrupt held until acknowledged
        wr(ra(3, 1), 32'd3);
        wait_fall(3, fall_cnt[3], "R6 first fire");
        repeat (100) @(negedge clk);
        check(irq_n[3] == 1'b0, "R6 irq held", 32'(irq_n[3]), 32'h0);
        wr(ra(3, 0), 32'h0);
        check(irq_n[3] == 1'b1, "R6 ack by count write", 32'(irq_n[3]), 32'h1);
        wr(ra(3, 1), 32'h8000_0003);

        // R7: bits 0 and 1 set, bit 1 ignored so channel 2 stays standalone
        wr(9'h100, 32'h3);
        wr(ra(2, 0), 32'h0);
        wr(ra(2, 1), 32'd3);
        measure(2, 32'd3, 32, "R7 overlap priority");
        wr(ra(2, 1), 32'h8000_0003);

        // R8 R10: pair 0-1, rollover clear, period 1+L+H*(L+1) = 9 ticks
        wr(9'h100, 32'h1);
        wr(ra(0, 1), 32'd2);
        n0 = fall_cnt[0];
        wr(ra(1, 1), 32'd2);
        measure(1, 32'd2, 72, "R8 chained period");
        check(fall_cnt[0] == n0 && irq_n[0], "R10 lower quiet", 32'(fall_cnt[0]), 32'(n0));

        // R9: rollover set, lower reloads 0xFFFFFFFE after borrow
        wr(ra(1, 1), 32'h8000_0002);
        wr(ra(0, 0), 32'h0);
        wr(ra(1, 0), 32'h0);
        wr(9'h100, 32'h0100_0001);
        wr(ra(0, 1), 32'd3);
        wr(ra(1, 1), 32'd1);
        repeat (100) @(negedge clk);
        rd(ra(1, 0), v); check(v == 32'h0, "R9 upper borrowed", v, 32'h0);
        rd(ra(0, 0), v);
        check(v > 32'hFFFF_FF00 && v <= 32'hFFFF_FFFE, "R9 lower rollover", v, 32'hFFFF_FFF8);
        check(irq_n[1] == 1'b1, "R10 no early fire", 32'(irq_n[1]), 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule